// File: doc/BRIEF.md
# Dual DAC Load and Update Interface

This block sits between a host byte/word register bus and two digital-to-analog converters. Each channel has a holding register, which the host fills one byte at a time or as a whole word, and an output latch that feeds the converter. A static strap picks how the holding contents reach the latches. In individual mode, writing a channel's high byte moves that channel's holding value to its output. In simultaneous mode, the host loads both channels without any visible change, and then any read of a DAC register moves both channels to the outputs in the same cycle.

A shared range register holds a 2-bit output-range code for each channel. The converters get these codes together with the 16-bit output codes. A parameter selects a 12-bit variant. In that variant the data is left-justified in the 16-bit word, and the four lowest bits are forced to zero in both the holding register and the output latch.

Top module: `dac_pair_load`

## Requirements
- R1: While reset is active and after it is released, both output codes and both range codes are zero.
- R2: A byte write places `bus_wdata_i[7:0]` in channel n's holding register: in the low byte for offset 4+2n and in the high byte for offset 5+2n. A low-byte write alone never changes an output.
- R3: In individual mode (`sim_mode_i`=0), a byte write to offset 5+2n sets channel n's output on the next clock edge. The new output is the written high byte joined with the low byte that was stored before.
- R4: In individual mode, a word write (`bus_word_i`=1) to offset 4+2n or 5+2n loads all 16 bits of `bus_wdata_i` into channel n's holding register and its output in one cycle.
- R5: In individual mode, reads have no effect on either output.
- R6: In simultaneous mode (`sim_mode_i`=1), byte and word writes change the holding registers but never the outputs.
- R7: In simultaneous mode, a read at any offset from 4 to 7 copies both holding registers to both outputs on the next edge. A read at any other offset has no effect.
- R8: In simultaneous mode, if a read of offsets 4 to 7 and a DAC write fall in the same cycle, the outputs take the holding contents from before that write. The written data stays held and appears at the next transfer.
- R9: A byte or word write to offset 10 loads bits 5:4 of the written data as channel 0's range code and bits 7:6 as channel 1's range code. All other bits are ignored, and the output codes do not change.
- R10: With `DATA_BITS`=12, bits 3:0 of both output codes are always zero, and bits 15:4 follow the same rules as in the 16-bit build.
- R11: Writes to offsets other than 4 to 7 and 10 change no output and no holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sim_mode_i | input | 1 | Update-policy strap: 0 individual, 1 simultaneous |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_word_i | input | 1 | 1: 16-bit word access, 0: byte access |
| bus_wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| dac0_code_o | output | 16 | Channel 0 output code |
| dac1_code_o | output | 16 | Channel 1 output code |
| dac0_range_o | output | 2 | Channel 0 range code |
| dac1_range_o | output | 2 | Channel 1 range code |

## Verification
In simultaneous mode, a transfer read and a DAC holding-register write can land in the same cycle. The bench raises both strobes together, with a word write to channel 0 and a read of a DAC offset. It then checks that the outputs show the holding values from before the write. A second, plain read afterwards must expose the newly written word. A 12-bit instance runs the same sweeps alongside, and its outputs are compared against the expected values with the four lowest bits cleared.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  localparam int NUM_CH    = 2;
  localparam int DAC_BASE  = 4;   // channel n: low byte at 4+2n, high byte at 5+2n
  localparam int RANGE_OFS = 10;
  localparam int RANGE_LSB = 4;   // channel n range at bits 5+2n:4+2n

  typedef struct packed {
    logic lo_we;
    logic hi_we;
    logic word_we;
  } chan_wr_t;
endpackage

// File: rtl/dac_pair_decode.sv
module dac_pair_decode
  import dac_pair_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              word_i,
  output chan_wr_t          cmd_o [NUM_CH],
  output logic              rng_we_o,
  output logic              dac_rd_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DAC_BASE);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DAC_BASE + 2*NUM_CH - 1);
  localparam logic [ADDR_W-1:0] RNG  = ADDR_W'(RANGE_OFS);

  logic [ADDR_W-1:0] off;
  logic              in_dac;

  assign off      = addr_i - BASE;
  assign in_dac   = (addr_i >= BASE) && (addr_i <= LAST);
  assign rng_we_o = wr_i && (addr_i == RNG);
  assign dac_rd_o = rd_i && in_dac;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-2:0] IDX = (ADDR_W-1)'(n);
    logic hit;
    assign hit = in_dac && (off[ADDR_W-1:1] == IDX);
    assign cmd_o[n] = '{lo_we:   wr_i && !word_i && hit && !off[0],
                        hi_we:   wr_i && !word_i && hit &&  off[0],
                        word_we: wr_i &&  word_i && hit};
  end
endmodule

// File: rtl/dac_pair_chan.sv
module dac_pair_chan
  import dac_pair_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  chan_wr_t    cmd_i,
  input  logic        sim_i,
  input  logic        xfer_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] code_o
);
  localparam int          PAD  = 16 - DATA_BITS;
  localparam logic [15:0] KEEP = 16'hFFFF << PAD;

  logic [15:0] hold_q, hold_d, code_q;
  logic        commit_new, commit_old;

  always_comb begin
    hold_d = hold_q;
    if (cmd_i.word_we) hold_d = wdata_i;
    else begin
      if (cmd_i.lo_we) hold_d[7:0]  = wdata_i[7:0];
      if (cmd_i.hi_we) hold_d[15:8] = wdata_i[7:0];
    end
    hold_d = hold_d & KEEP;
  end

  // individual: commit incoming value; simultaneous: commit value held before this cycle
  assign commit_new = !sim_i && (cmd_i.hi_we || cmd_i.word_we);
  assign commit_old =  sim_i && xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      code_q <= '0;
    end else begin
      hold_q <= hold_d;
      if (commit_new)      code_q <= hold_d;
      else if (commit_old) code_q <= hold_q;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/dac_pair_range.sv
module dac_pair_range
  import dac_pair_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [1:0] range_o [NUM_CH]
);
  logic [2*NUM_CH-1:0] rng_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rng_q <= '0;
    else if (we_i) rng_q <= wdata_i[RANGE_LSB +: 2*NUM_CH];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_out
    assign range_o[n] = rng_q[2*n +: 2];
  end
endmodule

// File: rtl/dac_pair_load.sv
module dac_pair_load
  import dac_pair_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sim_mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       dac0_code_o,
  output logic [15:0]       dac1_code_o,
  output logic [1:0]        dac0_range_o,
  output logic [1:0]        dac1_range_o
);
  chan_wr_t    cmd [NUM_CH];
  logic        rng_we, dac_rd;
  logic [15:0] code [NUM_CH];
  logic [1:0]  rng  [NUM_CH];

  dac_pair_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .word_i   (bus_word_i),
    .cmd_o    (cmd),
    .rng_we_o (rng_we),
    .dac_rd_o (dac_rd)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    dac_pair_chan #(.DATA_BITS(DATA_BITS)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_i   (cmd[n]),
      .sim_i   (sim_mode_i),
      .xfer_i  (dac_rd),
      .wdata_i (bus_wdata_i),
      .code_o  (code[n])
    );
  end

  dac_pair_range u_rng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rng_we),
    .wdata_i (bus_wdata_i[7:0]),
    .range_o (rng)
  );

  assign dac0_code_o  = code[0];
  assign dac1_code_o  = code[1];
  assign dac0_range_o = rng[0];
  assign dac1_range_o = rng[1];
endmodule

// File: rtl/dac_pair_chk.sv
module dac_pair_chk #(
  parameter int DATA_BITS = 16,
  parameter int ADDR_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sim_mode_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic              bus_word_i,
  input logic [15:0]       bus_wdata_i,
  input logic [15:0]       dac0_code_o,
  input logic [15:0]       dac1_code_o,
  input logic [1:0]        dac0_range_o,
  input logic [1:0]        dac1_range_o
);
  localparam logic [15:0] KEEP = 16'hFFFF << (16 - DATA_BITS);

  logic dac_ofs;
  assign dac_ofs = (bus_addr_i >= ADDR_W'(4)) && (bus_addr_i <= ADDR_W'(7));

  assert_ind_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sim_mode_i && bus_wr_i && bus_word_i && bus_addr_i == ADDR_W'(4))
      |=> dac0_code_o == ($past(bus_wdata_i) & KEEP));

  assert_ind_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sim_mode_i && !bus_wr_i && bus_rd_i)
      |=> ($stable(dac0_code_o) && $stable(dac1_code_o)));

  assert_sim_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sim_mode_i && bus_wr_i && !bus_rd_i)
      |=> ($stable(dac0_code_o) && $stable(dac1_code_o)));

  assert_range_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(10))
      |=> (dac0_range_o == $past(bus_wdata_i[5:4]) && dac1_range_o == $past(bus_wdata_i[7:6])));

  assert_other_ofs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_rd_i && !dac_ofs)
      |=> ($stable(dac0_code_o) && $stable(dac1_code_o)));

  assert_low_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac0_code_o & ~KEEP) == 16'h0) && ((dac1_code_o & ~KEEP) == 16'h0));
endmodule

bind dac_pair_load dac_pair_chk #(.DATA_BITS(DATA_BITS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sim_mode_i   (sim_mode_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_word_i   (bus_word_i),
  .bus_wdata_i  (bus_wdata_i),
  .dac0_code_o  (dac0_code_o),
  .dac1_code_o  (dac1_code_o),
  .dac0_range_o (dac0_range_o),
  .dac1_range_o (dac1_range_o)
);

// File: tb/dac_pair_load_test.sv
module dac_pair_load_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sim = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, word = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] c0, c1, d0, d1;
  logic [1:0]  r0, r1, e0, e1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [15:0] m_hold [2];
  logic [15:0] m_out  [2];
  logic [3:0]  m_rng;

  always #4 clk = ~clk;

  dac_pair_load uut (
    .clk_i(clk), .rst_ni(rst_n), .sim_mode_i(sim), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_word_i(word), .bus_wdata_i(wdata),
    .dac0_code_o(c0), .dac1_code_o(c1), .dac0_range_o(r0), .dac1_range_o(r1));

  dac_pair_load #(.DATA_BITS(12)) uut12 (
    .clk_i(clk), .rst_ni(rst_n), .sim_mode_i(sim), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_word_i(word), .bus_wdata_i(wdata),
    .dac0_code_o(d0), .dac1_code_o(d1), .dac0_range_o(e0), .dac1_range_o(e1));

  task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk(input string req);
    cmp(req, "ch0 code", c0, m_out[0]);
    cmp(req, "ch1 code", c1, m_out[1]);
    cmp(req, "ch0 range", {14'd0, r0}, {14'd0, m_rng[1:0]});
    cmp(req, "ch1 range", {14'd0, r1}, {14'd0, m_rng[3:2]});
    cmp("R10", "12b ch0 code", d0, m_out[0] & 16'hFFF0);
    cmp("R10", "12b ch1 code", d1, m_out[1] & 16'hFFF0);
  endtask

  // reference model, applied at the cycle the strobes are driven
  task automatic model(input logic w, input logic r, input logic wd, input logic [3:0] a, input logic [15:0] d);
    logic [15:0] old_hold [2];
    old_hold = m_hold;
    if (w) begin
      if (a >= 4 && a <= 7) begin
        int ch = (a - 4) >> 1;
        if (wd) begin
          m_hold[ch] = d;
          if (!sim) m_out[ch] = d;
        end else if (!a[0]) m_hold[ch][7:0] = d[7:0];
        else begin
          m_hold[ch][15:8] = d[7:0];
          if (!sim) m_out[ch] = m_hold[ch];
        end
      end else if (a == 4'd10) m_rng = d[7:4];
    end
    if (r && sim && a >= 4 && a <= 7) m_out = old_hold;
  endtask

  task automatic op(input logic w, input logic r, input logic wd, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = w; rd = r; word = wd; addr = a; wdata = d;
    model(w, r, wd, a, d);
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0; word = 1'b0;
  endtask

  task automatic set_mode(input logic s);
    @(negedge clk);
    sim = s;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    m_hold = '{16'h0, 16'h0};
    m_out  = '{16'h0, 16'h0};
    m_rng  = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1");

    // individual mode: byte pairs and word writes per channel
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] v = 16'(i * 16'h1357) ^ 16'hA5C3 ^ 16'(n * 16'h0F0F);
        op(1, 0, 0, 4'(4 + 2*n), {8'h00, v[7:0]});
        chk("R2");
        op(1, 0, 0, 4'(5 + 2*n), {8'h00, v[15:8]});
        chk("R3");
        op(1, 0, 1, 4'(4 + 2*n + (i % 2)), ~v);
        chk("R4");
      end
    end
    for (int a = 0; a < 16; a++) begin
      op(0, 1, 0, 4'(a), 16'h0);
      chk("R5");
    end

    // all offsets, byte and word writes
    for (int a = 0; a < 16; a++) begin
      op(1, 0, 0, 4'(a), 16'h00C9 + 16'(a));
      chk((a >= 4 && a <= 7) ? "R2" : (a == 10 ? "R9" : "R11"));
      op(1, 0, 1, 4'(a), 16'h7E00 + 16'(a * 16'h0111));
      chk((a >= 4 && a <= 7) ? "R4" : (a == 10 ? "R9" : "R11"));
    end

    // range register sweep
    for (int j = 0; j < 16; j++) begin
      op(1, 0, j % 2, 4'd10, 16'hA50F ^ 16'(j << 4));
      chk("R9");
    end

    // simultaneous mode
    set_mode(1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v = 16'(i * 16'h2B4D) ^ 16'h1E87;
      op(1, 0, 1, 4'd4, v);
      chk("R6");
      op(1, 0, 0, 4'd6, {8'h00, ~v[7:0]});
      chk("R6");
      op(1, 0, 0, 4'd7, {8'h00, v[7:0]});
      chk("R6");
      op(0, 1, 0, 4'(i % 16 + 8), 16'h0);
      chk("R7");
      op(0, 1, 0, 4'(4 + i % 4), 16'h0);
      chk("R7");
    end
    // reads at non-DAC offsets after new loads
    op(1, 0, 1, 4'd5, 16'h3C5A);
    for (int a = 0; a < 16; a++) begin
      if (a < 4 || a > 7) begin
        op(0, 1, 0, 4'(a), 16'h0);
        chk("R7");
      end
    end

    // collision: read-transfer and holding write in one cycle
    op(1, 0, 1, 4'd4, 16'h1111);
    op(0, 1, 0, 4'd7, 16'h0);
    chk("R8");
    op(1, 1, 1, 4'd4, 16'hBEEF);
    chk("R8");
    op(0, 1, 0, 4'd5, 16'h0);
    chk("R8");
    op(1, 1, 0, 4'd7, 16'h0042);
    chk("R8");
    op(0, 1, 0, 4'd6, 16'h0);
    chk("R8");

    // back to individual mode: pending low byte joins new high byte
    set_mode(1'b0);
    op(1, 0, 0, 4'd6, 16'h0077);
    chk("R2");
    op(1, 0, 0, 4'd7, 16'h0099);
    chk("R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule